// File: doc/BRIEF.md
# Dual Warp Issue Arbiter

This block decides, every clock, which warp instructions two warp schedulers hand to a shared group of execution pipelines. The even scheduler serves only even-numbered warps and the odd scheduler only odd-numbered warps. The pipelines are pooled, so either scheduler may use any pipeline of the class it needs. Each warp presents a ready flag and a two-bit instruction class. The block returns, per scheduler, a registered grant naming the warp and the pipeline it was sent to.

Each pipeline holds a busy counter. An issue loads the counter with the pipeline's occupancy, which is 2 cycles for the 16-lane arithmetic pipelines and 8 cycles for the 4-lane special-function pipeline. The pipeline takes no new instruction until its counter has run out. Within a scheduler, warps are served round-robin. A warp whose class currently has no free pipeline is skipped. When both schedulers need the last free pipeline of a class, a fairness bit kept for that class picks the winner and flips after each such conflict. The losing scheduler issues nothing that cycle.

Top module: `dual_issue_arbiter`

## Requirements
- R1: The even grant only ever carries an even warp ID, and the odd grant only ever carries an odd warp ID.
- R2: Pipelines are shared. When both schedulers want arithmetic pipelines and two are free, both issue in the same cycle. The even grant takes the lower-numbered free pipeline and the odd grant takes the next one. The two grants never name the same pipeline.
- R3: Class codes map to pipelines as follows. Code 0 (integer or single precision) and code 1 (double precision) go to the arithmetic pipelines, IDs 0 and 1. Code 2 (transcendental) goes to the special-function pipeline, ID 2. A warp with code 3 is never granted.
- R4: An arithmetic pipeline that receives an instruction on edge n can next receive one on edge n+2.
- R5: The special-function pipeline that receives an instruction on edge n can next receive one on edge n+8.
- R6: Each scheduler issues at most one instruction per cycle, and only to a pipeline whose busy counter is zero. It uses the lowest-numbered free pipeline of the class, after any pipeline already taken by the even side.
- R7: Within a scheduler, the ready warps are served round-robin. The search starts at the warp after the one issued last.
- R8: When both schedulers need a class that has only one free pipeline, one scheduler wins and the other issues nothing that cycle. The first such conflict after reset goes to the even side. Each later conflict on that class goes to the side that lost the previous one.
- R9: Inputs are sampled on a rising edge, and the resulting grant is visible from that edge until the next.
- R10: While reset is low, both grants are deasserted. After reset, all pipelines are free, and each scheduler's first grant goes to its lowest-numbered ready warp.
- R11: A ready warp whose class has no free pipeline is skipped, so a ready warp of another class in the same scheduler can issue instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| warp_ready | input | NUM_WARPS | One ready flag per warp |
| warp_class | input | 2*NUM_WARPS | Two-bit class code per warp, warp w at bits [2w+1:2w] |
| even_valid | output | 1 | Even scheduler issued this cycle |
| even_warp | output | WARP_W | Warp ID of the even grant |
| even_pipe | output | PIPE_W | Pipeline ID of the even grant |
| odd_valid | output | 1 | Odd scheduler issued this cycle |
| odd_warp | output | WARP_W | Warp ID of the odd grant |
| odd_pipe | output | PIPE_W | Pipeline ID of the odd grant |

## Verification
The bench builds the block with eight warps, giving four round-robin slots per scheduler, two arithmetic pipelines with occupancy 2, and one special-function pipeline with occupancy 8. With these values the round-robin wraps after only a few issues. A state where one arithmetic pipeline is free and the other busy arises, so conflicts on a pool with two pipelines can be checked. The eight-cycle special-function window is short enough to cover three conflict rounds and show the winner alternating. The bench also mixes classes inside one scheduler, which exercises the skip over a warp whose pipeline is busy.

// File: rtl/dia_pkg.sv
`timescale 1ns/1ps
package dia_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_DBL = 2'd1,
    CLS_SFU = 2'd2,
    CLS_RSV = 2'd3
  } instr_cls_e;

  localparam int POOL_ARITH = 0;
  localparam int POOL_SFU   = 1;
  localparam int NUM_POOLS  = 2;

  function automatic int pool_of(logic [1:0] code);
    return (code == CLS_SFU) ? POOL_SFU : POOL_ARITH;
  endfunction

  function automatic logic cls_issuable(logic [1:0] code);
    return code != CLS_RSV;
  endfunction

endpackage

// File: rtl/dia_busy_track.sv
`timescale 1ns/1ps
module dia_busy_track #(
  parameter int NUM_PIPES = 3,
  parameter int NUM_ARITH = 2,
  parameter int ARITH_OCC = 2,
  parameter int SFU_OCC   = 8,
  parameter int CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] load,
  output logic [NUM_PIPES-1:0] free
);

  for (genvar gi = 0; gi < NUM_PIPES; gi++) begin : g_pipe
    localparam int OCC = (gi < NUM_ARITH) ? ARITH_OCC : SFU_OCC;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = load[gi] || (cnt_q != '0);
      if (load[gi]) cnt_d = CNT_W'(OCC - 1);
      else          cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign free[gi] = (cnt_q == '0);

    assert_load_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load[gi] |-> (cnt_q == '0));
  end

endmodule

// File: rtl/dia_sched.sv
`timescale 1ns/1ps
module dia_sched #(
  parameter int LOCAL = 4,
  parameter int LOC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOCAL-1:0] elig,
  input  logic             advance,
  output logic             found,
  output logic [LOC_W-1:0] pick
);

  logic [LOC_W-1:0] last_q, last_d;

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= LOCAL; k++) begin
      idx = (int'(last_q) + k) % LOCAL;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = LOC_W'(idx);
      end
    end
    last_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= LOC_W'(LOCAL - 1);
    else if (advance) last_q <= last_d;
  end

  assert_adv_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> found);

endmodule

// File: rtl/dia_pool_arb.sv
`timescale 1ns/1ps
module dia_pool_arb #(
  parameter int NUM_PIPES = 3,
  parameter int LO        = 0,
  parameter int CNT       = 2,
  parameter int PIPE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] free,
  input  logic                 want_e,
  input  logic                 want_o,
  output logic                 any_free,
  output logic                 grant_e,
  output logic                 grant_o,
  output logic [PIPE_W-1:0]    pipe_e,
  output logic [PIPE_W-1:0]    pipe_o
);

  logic              have1, have2;
  logic [PIPE_W-1:0] first, second;
  logic              pri_q, pri_d, pri_en;
  logic              contend;

  always_comb begin
    have1  = 1'b0;
    have2  = 1'b0;
    first  = '0;
    second = '0;
    for (int i = LO; i < LO + CNT; i++) begin
      if (free[i]) begin
        if (!have1) begin
          have1 = 1'b1;
          first = PIPE_W'(i);
        end else if (!have2) begin
          have2  = 1'b1;
          second = PIPE_W'(i);
        end
      end
    end
  end

  assign any_free = have1;

  always_comb begin
    contend = want_e && want_o && have1 && !have2;
    grant_e = 1'b0;
    grant_o = 1'b0;
    pipe_e  = first;
    pipe_o  = first;
    if (want_e && want_o && have2) begin
      grant_e = 1'b1;
      grant_o = 1'b1;
      pipe_o  = second;
    end else if (contend) begin
      grant_e = !pri_q;
      grant_o = pri_q;
    end else begin
      grant_e = want_e && have1;
      grant_o = want_o && have1;
    end
    pri_en = contend;
    pri_d  = !pri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pri_q <= 1'b0;
    else if (pri_en) pri_q <= pri_d;
  end

  assert_alt_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_e) ##1 contend |-> grant_o);

  assert_alt_odd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && grant_o) ##1 contend |-> grant_e);

endmodule

// File: rtl/dual_issue_arbiter.sv
`timescale 1ns/1ps
module dual_issue_arbiter
  import dia_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int NUM_ARITH = 2,
  parameter int NUM_SFU   = 1,
  parameter int ARITH_OCC = 2,
  parameter int SFU_OCC   = 8,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int NUM_PIPES = NUM_ARITH + NUM_SFU,
  localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WARPS-1:0]   warp_ready,
  input  logic [2*NUM_WARPS-1:0] warp_class,
  output logic                   even_valid,
  output logic [WARP_W-1:0]      even_warp,
  output logic [PIPE_W-1:0]      even_pipe,
  output logic                   odd_valid,
  output logic [WARP_W-1:0]      odd_warp,
  output logic [PIPE_W-1:0]      odd_pipe
);

  localparam int LOCAL   = NUM_WARPS / 2;
  localparam int LOC_W   = (LOCAL > 1) ? $clog2(LOCAL) : 1;
  localparam int MAX_OCC = (ARITH_OCC > SFU_OCC) ? ARITH_OCC : SFU_OCC;
  localparam int CNT_W   = (MAX_OCC > 2) ? $clog2(MAX_OCC) : 1;

  logic [1:0]        cls      [NUM_WARPS];
  logic [LOCAL-1:0]  elig     [2];
  logic              found    [2];
  logic [LOC_W-1:0]  pick     [2];
  logic              iss      [2];
  logic [PIPE_W-1:0] ipipe    [2];
  logic              pool_any [NUM_POOLS];
  logic              want     [NUM_POOLS][2];
  logic              gnt      [NUM_POOLS][2];
  logic [PIPE_W-1:0] gpipe    [NUM_POOLS][2];
  logic [NUM_PIPES-1:0] free, load;

  logic              v_q [2];
  logic [WARP_W-1:0] w_q [2], w_d [2];
  logic [PIPE_W-1:0] p_q [2];

  // eligibility: ready, issuable class, and a free pipe in that class's pool
  always_comb begin
    int w;
    for (int i = 0; i < NUM_WARPS; i++) cls[i] = warp_class[2*i +: 2];
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < LOCAL; i++) begin
        w = 2*i + s;
        elig[s][i] = warp_ready[w] && cls_issuable(cls[w]) && pool_any[pool_of(cls[w])];
      end
    end
  end

  for (genvar gs = 0; gs < 2; gs++) begin : g_side
    dia_sched #(.LOCAL(LOCAL), .LOC_W(LOC_W)) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig[gs]),
      .advance (iss[gs]),
      .found   (found[gs]),
      .pick    (pick[gs])
    );
  end

  // route each scheduler's choice to the pool of its class
  always_comb begin
    int w;
    for (int s = 0; s < 2; s++) begin
      w = 2*int'(pick[s]) + s;
      w_d[s] = WARP_W'(w);
      for (int p = 0; p < NUM_POOLS; p++)
        want[p][s] = found[s] && cls_issuable(cls[w]) && (pool_of(cls[w]) == p);
    end
  end

  for (genvar gp = 0; gp < NUM_POOLS; gp++) begin : g_pool
    localparam int LO  = (gp == POOL_ARITH) ? 0 : NUM_ARITH;
    localparam int CNT = (gp == POOL_ARITH) ? NUM_ARITH : NUM_SFU;
    dia_pool_arb #(.NUM_PIPES(NUM_PIPES), .LO(LO), .CNT(CNT), .PIPE_W(PIPE_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .free     (free),
      .want_e   (want[gp][0]),
      .want_o   (want[gp][1]),
      .any_free (pool_any[gp]),
      .grant_e  (gnt[gp][0]),
      .grant_o  (gnt[gp][1]),
      .pipe_e   (gpipe[gp][0]),
      .pipe_o   (gpipe[gp][1])
    );
  end

  always_comb begin
    load = '0;
    for (int s = 0; s < 2; s++) begin
      iss[s]   = gnt[POOL_ARITH][s] || gnt[POOL_SFU][s];
      ipipe[s] = gnt[POOL_SFU][s] ? gpipe[POOL_SFU][s] : gpipe[POOL_ARITH][s];
      if (iss[s]) load[ipipe[s]] = 1'b1;
    end
  end

  dia_busy_track #(
    .NUM_PIPES (NUM_PIPES),
    .NUM_ARITH (NUM_ARITH),
    .ARITH_OCC (ARITH_OCC),
    .SFU_OCC   (SFU_OCC),
    .CNT_W     (CNT_W)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .free  (free)
  );

  for (genvar gs = 0; gs < 2; gs++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[gs] <= 1'b0;
      else        v_q[gs] <= iss[gs];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q[gs] <= '0;
        p_q[gs] <= '0;
      end else if (iss[gs]) begin
        w_q[gs] <= w_d[gs];
        p_q[gs] <= ipipe[gs];
      end
    end

    assert_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[gs] |-> (w_q[gs][0] == 1'(gs)));

    assert_quiet_in_reset_R10: assert property (@(posedge clk)
      !rst_n |-> !v_q[gs]);

    if (ARITH_OCC > 1 && SFU_OCC > 1) begin : g_occ
      assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[gs] |=> !(v_q[0] && p_q[0] == $past(p_q[gs])) &&
                    !(v_q[1] && p_q[1] == $past(p_q[gs])));
    end
  end

  assert_distinct_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[0] && v_q[1]) |-> (p_q[0] != p_q[1]));

  assign even_valid = v_q[0];
  assign even_warp  = w_q[0];
  assign even_pipe  = p_q[0];
  assign odd_valid  = v_q[1];
  assign odd_warp   = w_q[1];
  assign odd_pipe   = p_q[1];

endmodule

// File: tb/dual_issue_arbiter_tb.sv
`timescale 1ns/1ps
module dual_issue_arbiter_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] warp_ready;
  logic [15:0] warp_class;
  logic       even_valid, odd_valid;
  logic [2:0] even_warp, odd_warp;
  logic [1:0] even_pipe, odd_pipe;

  int checks;
  int errors;
  bit done;

  dual_issue_arbiter #(
    .NUM_WARPS (8),
    .NUM_ARITH (2),
    .NUM_SFU   (1),
    .ARITH_OCC (2),
    .SFU_OCC   (8)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .warp_ready (warp_ready),
    .warp_class (warp_class),
    .even_valid (even_valid),
    .even_warp  (even_warp),
    .even_pipe  (even_pipe),
    .odd_valid  (odd_valid),
    .odd_warp   (odd_warp),
    .odd_pipe   (odd_pipe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic side_chk(string tag, string side, logic av, int aw, int ap,
                          bit ev, int ew, int ep);
    bit bad;
    checks++;
    bad = (av !== ev) || (ev && (aw != ew || ap != ep));
    if (bad) begin
      errors++;
      $display("FAIL %s %s: got v=%0b w=%0d p=%0d, expected v=%0b w=%0d p=%0d",
               tag, side, av, aw, ap, ev, ew, ep);
    end
  endtask

  task automatic expect2(string tag, bit ev, int ew, int ep, bit ov, int ow, int op);
    side_chk(tag, "even", even_valid, int'(even_warp), int'(even_pipe), ev, ew, ep);
    side_chk(tag, "odd",  odd_valid,  int'(odd_warp),  int'(odd_pipe),  ov, ow, op);
  endtask

  task automatic set_warp(int w, bit rdy, logic [1:0] c);
    warp_ready[w]       = rdy;
    warp_class[2*w +: 2] = c;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    warp_ready = '0;
    warp_class = '0;
    repeat (2) @(negedge clk);
  endtask

  // release at a falling edge; the next rising edge is edge 1
  task automatic leave_reset();
    rst_n = 1'b1;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_parity();
    enter_reset();
    for (int w = 0; w < 8; w++) set_warp(w, 1'b1, 2'd0);
    edges(1);
    expect2("R10 grants low in reset", 0, 0, 0, 0, 0, 0);
    leave_reset();
    expect2("R10 no grant before first edge", 0, 0, 0, 0, 0, 0);
    edges(1);
    expect2("R10 R1 R2 first grants", 1, 0, 0, 1, 1, 1);
    edges(1);
    expect2("R4 both arith busy", 0, 0, 0, 0, 0, 0);
    edges(1);
    expect2("R1 R7 next warps per side", 1, 2, 0, 1, 3, 1);
  endtask

  task automatic t_single_arith();
    enter_reset();
    set_warp(0, 1'b1, 2'd0);
    leave_reset();
    edges(1);
    expect2("R6 lone warp pipe 0", 1, 0, 0, 0, 0, 0);
    edges(1);
    expect2("R6 lone warp pipe 1", 1, 0, 1, 0, 0, 0);
    edges(1);
    expect2("R4 pipe 0 free after 2", 1, 0, 0, 0, 0, 0);
    set_warp(0, 1'b0, 2'd0);
    edges(1);
    expect2("R9 ready drop seen next edge", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_double();
    enter_reset();
    set_warp(2, 1'b1, 2'd1);
    set_warp(3, 1'b1, 2'd1);
    leave_reset();
    edges(1);
    expect2("R3 double on arith pipes", 1, 2, 0, 1, 3, 1);
    edges(1);
    expect2("R3 R4 double occupancy", 0, 0, 0, 0, 0, 0);
    edges(1);
    expect2("R3 double reissue", 1, 2, 0, 1, 3, 1);
  endtask

  task automatic t_round_robin();
    int exp_w [5] = '{0, 2, 4, 0, 2};
    enter_reset();
    set_warp(0, 1'b1, 2'd0);
    set_warp(2, 1'b1, 2'd0);
    set_warp(4, 1'b1, 2'd0);
    leave_reset();
    for (int k = 0; k < 5; k++) begin
      edges(1);
      expect2("R7 round robin", 1, exp_w[k], k % 2, 0, 0, 0);
    end
  endtask

  task automatic t_sfu();
    enter_reset();
    set_warp(5, 1'b1, 2'd2);
    leave_reset();
    edges(1);
    expect2("R3 R5 sfu pipe 2", 0, 0, 0, 1, 5, 2);
    edges(1);
    expect2("R5 sfu busy", 0, 0, 0, 0, 0, 0);
    edges(6);
    expect2("R5 sfu busy at 7", 0, 0, 0, 0, 0, 0);
    edges(1);
    expect2("R5 sfu free at 8", 0, 0, 0, 1, 5, 2);
  endtask

  task automatic t_sfu_contend();
    enter_reset();
    set_warp(0, 1'b1, 2'd2);
    set_warp(1, 1'b1, 2'd2);
    leave_reset();
    edges(1);
    expect2("R8 first conflict to even", 1, 0, 2, 0, 0, 0);
    edges(1);
    expect2("R8 R5 nobody while busy", 0, 0, 0, 0, 0, 0);
    edges(7);
    expect2("R8 second conflict to odd", 0, 0, 0, 1, 1, 2);
    edges(8);
    expect2("R8 third conflict to even", 1, 0, 2, 0, 0, 0);
  endtask

  task automatic t_arith_contend();
    enter_reset();
    set_warp(0, 1'b1, 2'd0);
    set_warp(1, 1'b0, 2'd0);
    leave_reset();
    edges(1);
    expect2("R8 setup even alone", 1, 0, 0, 0, 0, 0);
    set_warp(1, 1'b1, 2'd0);
    edges(1);
    expect2("R8 one arith free, even wins", 1, 0, 1, 0, 0, 0);
    edges(1);
    expect2("R8 one arith free, odd wins", 0, 0, 0, 1, 1, 0);
    edges(1);
    expect2("R8 one arith free, even again", 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_skip_busy();
    enter_reset();
    set_warp(0, 1'b1, 2'd2);
    set_warp(2, 1'b1, 2'd0);
    leave_reset();
    edges(1);
    expect2("R11 sfu warp first", 1, 0, 2, 0, 0, 0);
    edges(1);
    expect2("R11 skip busy sfu warp", 1, 2, 0, 0, 0, 0);
    edges(1);
    expect2("R11 arith warp again", 1, 2, 1, 0, 0, 0);
    edges(6);
    expect2("R11 R7 sfu warp back at 8", 1, 0, 2, 0, 0, 0);
  endtask

  task automatic t_reserved();
    enter_reset();
    set_warp(0, 1'b1, 2'd3);
    set_warp(1, 1'b1, 2'd3);
    leave_reset();
    edges(1);
    expect2("R3 code 3 not granted", 0, 0, 0, 0, 0, 0);
    edges(5);
    expect2("R3 code 3 still not granted", 0, 0, 0, 0, 0, 0);
    set_warp(0, 1'b1, 2'd0);
    edges(1);
    expect2("R3 code 0 granted", 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    warp_ready = '0;
    warp_class = '0;
    t_reset_parity();
    t_single_arith();
    t_double();
    t_round_robin();
    t_sfu();
    t_sfu_contend();
    t_arith_contend();
    t_skip_busy();
    t_reserved();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no end, expected end of tests");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule